// File: doc/BRIEF.md
# Gamepad Serial Shift Register

This block sits on a processor bus as a small slave and turns two parallel sets of eight button lines into serial streams. Software writes a strobe bit to the first port address. While that bit is high, both pads keep loading their button lines. When software clears it, the states present at that moment are frozen. Each later read of a port address returns one button on data bit 0 and advances only that port's register.

The button lines are active-high, so a pressed button reads back as 1. Each pad has a fixed serial order, starting with the A button. When all eight buttons have been read out, a port returns 1 on every further read until the next latch. Both ports share the strobe. Each port keeps its own read position.

Top module: `gamepad_serial_port`

## Requirements
- R1: After synchronous reset the strobe is low and both shift registers hold all ones, so every read of either port returns 1 on bit 0.
- R2: A write to the strobe address (0x4016) copies wdata bit 0 into the strobe. The write that takes the strobe from 1 to 0 freezes both pads' button vectors as sampled in that write's cycle, and later button changes do not alter the frozen values.
- R3: Button vector bit k holds button k of the serial order (0=A, 1=B, 2=Select, 3=Start, 4=Up, 5=Down, 6=Left, 7=Right), with 1 meaning pressed. The n-th read after a latch (n = 1..8) returns bit n-1 on rdata bit 0.
- R4: A read of address 0x4016 serves pad 0 and a read of address 0x4017 serves pad 1.
- R5: While the strobe is 1, a read of either port returns the live state of that pad's A button (bit 0) and does not advance the port.
- R6: After eight reads of a port since the last latch, every further read of that port returns 1.
- R7: A port's register shifts only on a read of its own address. Reads of the other port leave its position unchanged.
- R8: rdata bits 7..1 are always 0. rdata is entirely 0 in any cycle without a read of a port address.
- R9: Writes to any address other than the strobe address, including the pad 1 address, have no effect on the strobe or the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle; the port advances at the clock edge that ends the cycle |
| bus_wdata | input | 8 | Write data; bit 0 is the strobe value |
| bus_rdata | output | 8 | Read data, combinational during a read cycle |
| pad0_buttons | input | 8 | Pad 0 buttons, bit k = serial position k, 1 = pressed |
| pad1_buttons | input | 8 | Pad 1 buttons, same encoding |

## Verification
The bench builds the block with its default parameters: eight buttons per pad, two ports and a 16-bit address. These are small enough to sweep all 256 button patterns on pad 0 while pad 1 carries the complement. Each pattern goes through a full latch, eight reads of each port in alternating order, and the reads past the end. Separate passes cover these cases:
- live reads with the strobe held high
- reads of one port only
- stray writes to other addresses
- idle cycles, in which rdata must be zero

// File: rtl/pad_pkg.sv
package pad_pkg;

    localparam int BTN_COUNT      = 8;
    localparam int PORT_COUNT     = 2;
    localparam int BUS_ADDR_W     = 16;
    localparam int BUS_DATA_W     = 8;
    localparam logic [BUS_ADDR_W-1:0] PAD_BASE_ADDR = 16'h4016;

    // Serial position of each button in a pad's stream
    typedef enum logic [2:0] {
        BTN_A      = 3'd0,
        BTN_B      = 3'd1,
        BTN_SELECT = 3'd2,
        BTN_START  = 3'd3,
        BTN_UP     = 3'd4,
        BTN_DOWN   = 3'd5,
        BTN_LEFT   = 3'd6,
        BTN_RIGHT  = 3'd7
    } btn_pos_e;

    typedef struct packed {
        logic strobe_wr;
        logic strobe_val;
    } strobe_cmd_t;

    // True when addr names port idx
    function automatic logic port_hit(input logic [BUS_ADDR_W-1:0] addr,
                                      input logic [BUS_ADDR_W-1:0] base,
                                      input int unsigned idx);
        return addr == (base + BUS_ADDR_W'(idx));
    endfunction

endpackage

// File: rtl/pad_bus_decode.sv
module pad_bus_decode
    import pad_pkg::*;
#(
    parameter int ADDR_W = BUS_ADDR_W,
    parameter int DATA_W = BUS_DATA_W,
    parameter int NPORTS = PORT_COUNT,
    parameter logic [ADDR_W-1:0] BASE = PAD_BASE_ADDR
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output strobe_cmd_t       cmd,
    output logic [NPORTS-1:0] rd_sel
);

    always_comb begin
        cmd.strobe_wr  = bus_wr && (bus_addr == BASE);
        cmd.strobe_val = bus_wdata[0];
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_sel
        assign rd_sel[p] = bus_rd && port_hit(bus_addr, BASE, p);
    end

endmodule

// File: rtl/pad_strobe_ctl.sv
module pad_strobe_ctl
    import pad_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  strobe_cmd_t cmd,
    output logic        strobe_q
);

    always_ff @(posedge clk) begin
        if (rst)
            strobe_q <= 1'b0;
        else if (cmd.strobe_wr)
            strobe_q <= cmd.strobe_val;
    end

    // R9
    strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd.strobe_wr |=> $stable(strobe_q));

    // R2
    strobe_take_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.strobe_wr |=> strobe_q == $past(cmd.strobe_val));

endmodule

// File: rtl/pad_shifter.sv
module pad_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] buttons,
    output logic             head_bit
);

    logic [WIDTH-1:0] sreg_q;

    always_ff @(posedge clk) begin
        if (rst)
            sreg_q <= '1;
        else if (load)
            sreg_q <= buttons;
        else if (shift)
            sreg_q <= {1'b1, sreg_q[WIDTH-1:1]};
    end

    assign head_bit = sreg_q[0];

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> sreg_q == $past(buttons));

    // R6
    fill_one_chk: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> sreg_q[WIDTH-1]);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift) |=> $stable(sreg_q));

endmodule

// File: rtl/gamepad_serial_port.sv
module gamepad_serial_port
    import pad_pkg::*;
#(
    parameter int ADDR_W = BUS_ADDR_W,
    parameter int DATA_W = BUS_DATA_W,
    parameter int NBTN   = BTN_COUNT,
    parameter logic [ADDR_W-1:0] BASE = PAD_BASE_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NBTN-1:0]   pad0_buttons,
    input  logic [NBTN-1:0]   pad1_buttons
);

    localparam int NPORTS = 2;

    strobe_cmd_t       cmd;
    logic [NPORTS-1:0] rd_sel;
    logic              strobe_q;
    logic [NBTN-1:0]   pad_btn [NPORTS];
    logic [NPORTS-1:0] head;
    logic [NPORTS-1:0] port_bit;
    logic              read_bit;

    assign pad_btn[0] = pad0_buttons;
    assign pad_btn[1] = pad1_buttons;

    pad_bus_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NPORTS (NPORTS),
        .BASE   (BASE)
    ) u_dec (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cmd       (cmd),
        .rd_sel    (rd_sel)
    );

    pad_strobe_ctl u_strobe (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .strobe_q (strobe_q)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        pad_shifter #(.WIDTH(NBTN)) u_shift (
            .clk      (clk),
            .rst      (rst),
            .load     (strobe_q),
            .shift    (rd_sel[p]),
            .buttons  (pad_btn[p]),
            .head_bit (head[p])
        );
        // Live A button while strobed, frozen head otherwise
        assign port_bit[p] = rd_sel[p] & (strobe_q ? pad_btn[p][0] : head[p]);
    end

    assign read_bit  = |port_bit;
    assign bus_rdata = DATA_W'(read_bit);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> bus_rdata == '0);

    // R5
    live_a0_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_q && rd_sel[0]) |-> bus_rdata[0] == pad0_buttons[0]);

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_sel));

endmodule

// File: tb/tb_gamepad_serial_port.sv
module tb_gamepad_serial_port;

    localparam logic [15:0] A0 = 16'h4016;
    localparam logic [15:0] A1 = 16'h4017;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pad0 = '0;
    logic [7:0]  pad1 = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gamepad_serial_port dut (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pad0_buttons (pad0),
        .pad1_buttons (pad1)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    // Read port address a and return the whole data byte
    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic latch();
        bus_write(A0, 8'h01);
        bus_write(A0, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] held0, held1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state reads all ones on both ports
        bus_read(A0, d); chk("R1 port0 after reset", d, 1);
        bus_read(A1, d); chk("R1 port1 after reset", d, 1);

        // R8: idle cycle has zero data
        @(negedge clk); #1 chk("R8 idle rdata", bus_rdata, 0);

        // R3 R4 R6 R7: sweep every pattern, ports read alternately
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            pad0 = 8'(v); pad1 = ~8'(v);
            latch();
            // R2: later changes must not reach the frozen values
            @(negedge clk);
            pad0 = 8'(v) ^ 8'hA5; pad1 = 8'(v) ^ 8'h3C;
            for (int k = 0; k < 8; k++) begin
                bus_read(A0, d);
                chk("R3 pad0 serial bit", d, (v >> k) & 1);
                bus_read(A1, d);
                chk("R4 pad1 serial bit", d, ((~v) >> k) & 1);
            end
            for (int k = 0; k < 2; k++) begin
                bus_read(A0, d); chk("R6 pad0 past end", d, 1);
                bus_read(A1, d); chk("R6 pad1 past end", d, 1);
            end
        end

        // R7: drain pad1 alone, pad0 still starts at its first bit
        @(negedge clk); pad0 = 8'b1011_0010; pad1 = 8'b0110_1101;
        latch();
        for (int k = 0; k < 8; k++) begin
            bus_read(A1, d);
            chk("R7 pad1 alone", d, (8'b0110_1101 >> k) & 1);
        end
        for (int k = 0; k < 8; k++) begin
            bus_read(A0, d);
            chk("R7 pad0 untouched by pad1 reads", d, (8'b1011_0010 >> k) & 1);
        end

        // R5: strobe high gives live A and no shifting
        bus_write(A0, 8'h01);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); pad0 = {7'h55, k[0]}; pad1 = {7'h2A, ~k[0]};
            bus_read(A0, d); chk("R5 pad0 live A", d, k & 1);
            bus_read(A1, d); chk("R5 pad1 live A", d, (~k) & 1);
        end
        @(negedge clk); pad0 = 8'b1100_1010; pad1 = 8'b0011_0101;
        bus_write(A0, 8'hFE); // bit 0 clear: falls, latches
        @(negedge clk); pad0 = 8'h00; pad1 = 8'h00;
        for (int k = 0; k < 8; k++) begin
            bus_read(A0, d); chk("R2 pad0 latched at fall", d, (8'b1100_1010 >> k) & 1);
            bus_read(A1, d); chk("R2 pad1 latched at fall", d, (8'b0011_0101 >> k) & 1);
        end

        // R9: stray writes do not latch or change position
        @(negedge clk); pad0 = 8'b0101_0110; pad1 = 8'b1001_1001;
        latch();
        bus_read(A0, d); chk("R9 pad0 first", d, 0);
        @(negedge clk); pad0 = 8'hFF; pad1 = 8'h00;
        bus_write(A1, 8'h01);
        bus_write(16'h4015, 8'h01);
        bus_write(16'h0016, 8'h01);
        bus_read(A1, d); chk("R9 pad1 after stray writes", d, 1);
        held0 = 8'b0101_0110; held1 = 8'b1001_1001;
        for (int k = 1; k < 8; k++) begin
            bus_read(A0, d); chk("R9 pad0 rest", d, (held0 >> k) & 1);
            bus_read(A1, d); chk("R9 pad1 rest", d, (held1 >> k) & 1);
        end

        // R8: read of a non-port address returns zero
        bus_read(16'h4018, d); chk("R8 other address", d, 0);

        // R1: reset mid-stream restores all ones
        @(negedge clk); pad0 = 8'h00; latch();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        bus_read(A0, d); chk("R1 port0 after second reset", d, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule